// File: doc/BRIEF.md
# Three-Moduli Mixed-Radix Digit Stage

This block is the first level of a residue-to-binary converter for a residue system whose odd moduli are P1 = 2^N-1, P2 = 2^(N+1)-1 and P3 = 2^(N-1)-1, with N even and at least 4. It takes one residue per modulus and returns the three mixed-radix digits Z1, Z2 and Z3. A later stage recombines them as Y = Z1 + Z2·P1 + Z3·P1·P2. The sum Y itself is not formed here. The bitwise complement of Z2 is also output, because the next stage consumes it in negated form.

Z2 comes from an end-around-carry subtraction of two rotated words: L1 is x1 rotated left by one bit and L2 is x2 rotated left by one bit. This applies the constant factor -2 modulo P2.

Z3 does not wait for Z2. Its terms are gathered straight from the raw residues and folded into (N-1)-bit words. They are compressed by end-around-carry carry-save adders into a sum/carry pair. Each word of the pair is rotated by 0, 2, …, N-2 places, which multiplies it by the inverse of P2 modulo P3. The sign of L1-L2 selects a fixed correction operand. A final modulo 2^(N-1)-1 adder closes the path.

Two parameters control pipelining:
- MID_REG places a register bank between the carry-save front end and the rotation tree.
- OUT_REG registers the outputs.

The latency is MID_REG+OUT_REG cycles, and a new residue triple may be accepted every cycle.

Top module: `mrc3_stage`

## Requirements
- R1: z1_o equals x1_i.
- R2: z2_o equals (2·(x1 - x2)) mod P2, reduced into [0, P2-1].
- R3: z3_o equals ((x3 - x1 - Z2)·Q) mod P3 in [0, P3-1], where Q is the inverse of P2 modulo P3. Equivalently, (x1 + Z2 + P2·Z3) mod P3 equals x3.
- R4: z2n_o is the bitwise complement of all N+1 bits of z2_o.
- R5: The sign split of L1-L2 is exact. This covers L1 > L2, L1 < L2 (where a correction of (N-2) ones followed by a zero is added into Z3), and L1 = L2 (for example x1 = x2, where Z2 = 0 and no correction is added).
- R6: A digit whose value is congruent to zero is output as all zeros, never as the all-ones pattern. This holds for inputs (0,0,0) and for x3 ≡ x1 + Z2 mod P3.
- R7: Outputs appear MID_REG+OUT_REG rising edges after the inputs. While rst_n is low, every registered stage holds zero, so all of z1_o, z2_o and z3_o read 0 when latency is nonzero.
- R8: Back-to-back residue triples, one per cycle, each produce their own correct digits in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional pipeline registers |
| rst_n | input | 1 | Asynchronous active-low reset of the pipeline registers |
| x1_i | input | N | Residue modulo 2^N-1, in [0, P1-1] |
| x2_i | input | N+1 | Residue modulo 2^(N+1)-1, in [0, P2-1] |
| x3_i | input | N-1 | Residue modulo 2^(N-1)-1, in [0, P3-1] |
| z1_o | output | N | First mixed-radix digit |
| z2_o | output | N+1 | Second mixed-radix digit |
| z2n_o | output | N+1 | Bitwise complement of the second digit |
| z3_o | output | N-1 | Third mixed-radix digit |

## Verification
All four outputs for a triple are due MID_REG+OUT_REG rising edges after the falling edge on which that triple is driven. With the default parameters this is two edges. The bench queues each expected digit set when it drives the inputs. One nanosecond after each falling edge, it pops and compares the entry only once the queue holds more than the latency's worth of entries, so every compare lands exactly on the cycle its result is due. Reset values are read while reset is held. Inputs are changed meanwhile, to show that nothing propagates.

// File: rtl/mrc3_stage.sv
module mrc3_stage #(
  parameter int N       = 6,
  parameter bit MID_REG = 1'b1,
  parameter bit OUT_REG = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] x1_i,
  input  logic [N:0]   x2_i,
  input  logic [N-2:0] x3_i,
  output logic [N-1:0] z1_o,
  output logic [N:0]   z2_o,
  output logic [N:0]   z2n_o,
  output logic [N-2:0] z3_o
);
  localparam int W1   = N;
  localparam int W2   = N + 1;
  localparam int W3   = N - 1;
  localparam int HALF = N / 2;
  localparam int NOPA = 7;
  localparam int NOPB = N + 1;

  function automatic logic [W3-1:0] rotl(input logic [W3-1:0] v, input int k);
    logic [2*W3-1:0] t;
    t = {v, v} << k;
    return t[2*W3-1:W3];
  endfunction

  function automatic logic [2*W3-1:0] csa_eac(input logic [W3-1:0] a,
                                               input logic [W3-1:0] b,
                                               input logic [W3-1:0] c);
    logic [W3-1:0] s, cy;
    s  = a ^ b ^ c;
    cy = (a & b) | (a & c) | (b & c);
    return {cy[W3-2:0], cy[W3-1], s};
  endfunction

  // front end: Z2 subtractor and Z3 carry-save gathering
  logic [W2-1:0] l1, l2;
  logic [W2:0]   dsum;
  logic [W2-1:0] deac, z2_a;
  logic          neg_a;
  logic [W3-1:0] opa [NOPA];
  logic [W3-1:0] s1_a, c1_a;

  assign l1    = {x1_i, 1'b0};
  assign l2    = {x2_i[W2-2:0], x2_i[W2-1]};
  assign dsum  = {1'b0, l1} + {1'b0, ~l2};
  assign deac  = dsum[W2-1:0] + W2'(dsum[W2]);
  assign z2_a  = (deac == '1) ? '0 : deac;
  assign neg_a = ~dsum[W2] & (dsum[W2-1:0] != '1);

  assign opa[0] = x3_i;
  assign opa[1] = ~x1_i[W3-1:0];
  assign opa[2] = ~{{(W3-1){1'b0}}, x1_i[W1-1]};
  assign opa[3] = ~l1[W3-1:0];
  assign opa[4] = ~{{(W3-2){1'b0}}, l1[W2-1:W3]};
  assign opa[5] = l2[W3-1:0];
  assign opa[6] = {{(W3-2){1'b0}}, l2[W2-1:W3]};

  always_comb begin
    logic [2*W3-1:0] pr;
    pr = csa_eac(opa[0], opa[1], opa[2]);
    for (int k = 3; k < NOPA; k++) pr = csa_eac(pr[W3-1:0], pr[2*W3-1:W3], opa[k]);
    s1_a = pr[W3-1:0];
    c1_a = pr[2*W3-1:W3];
  end

  // optional middle register
  logic [W1-1:0] x1_b;
  logic [W2-1:0] z2_b;
  logic [W3-1:0] s1_b, c1_b;
  logic          neg_b;

  generate
    if (MID_REG) begin : g_mid
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          x1_b <= '0; z2_b <= '0; s1_b <= '0; c1_b <= '0; neg_b <= 1'b0;
        end else begin
          x1_b <= x1_i; z2_b <= z2_a; s1_b <= s1_a; c1_b <= c1_a; neg_b <= neg_a;
        end
      end
    end else begin : g_nomid
      assign x1_b = x1_i; assign z2_b = z2_a; assign s1_b = s1_a;
      assign c1_b = c1_a; assign neg_b = neg_a;
    end
  endgenerate

  // back end: inverse multiply by rotations, correction, modulo adder
  logic [W3-1:0] opb [NOPB];
  logic [W3-1:0] sb, cb, r3, z3_b;
  logic [W3:0]   madd;

  generate
    for (genvar g = 0; g < HALF; g++) begin : g_rot
      assign opb[2*g]   = rotl(s1_b, 2*g);
      assign opb[2*g+1] = rotl(c1_b, 2*g);
    end
  endgenerate
  assign opb[NOPB-1] = neg_b ? {{(W3-1){1'b1}}, 1'b0} : '0;

  always_comb begin
    logic [2*W3-1:0] pr;
    pr = csa_eac(opb[0], opb[1], opb[2]);
    for (int k = 3; k < NOPB; k++) pr = csa_eac(pr[W3-1:0], pr[2*W3-1:W3], opb[k]);
    sb = pr[W3-1:0];
    cb = pr[2*W3-1:W3];
  end

  assign madd = {1'b0, sb} + {1'b0, cb};
  assign r3   = madd[W3-1:0] + W3'(madd[W3]);
  assign z3_b = (r3 == '1) ? '0 : r3;

  // optional output register
  generate
    if (OUT_REG) begin : g_out
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          z1_o <= '0; z2_o <= '0; z2n_o <= '1; z3_o <= '0;
        end else begin
          z1_o <= x1_b; z2_o <= z2_b; z2n_o <= ~z2_b; z3_o <= z3_b;
        end
      end
    end else begin : g_noout
      assign z1_o = x1_b; assign z2_o = z2_b; assign z2n_o = ~z2_b; assign z3_o = z3_b;
    end
  endgenerate
endmodule

// File: rtl/mrc3_stage_chk.sv
module mrc3_stage_chk #(
  parameter int N   = 6,
  parameter int LAT = 2
) (
  input logic         clk,
  input logic         rst_n,
  input logic [N-1:0] x1_i,
  input logic [N:0]   x2_i,
  input logic [N-2:0] x3_i,
  input logic [N-1:0] z1_o,
  input logic [N:0]   z2_o,
  input logic [N-2:0] z3_o
);
  localparam int P2 = (1 << (N + 1)) - 1;
  localparam int P3 = (1 << (N - 1)) - 1;

  logic [N-1:0] x1_d;
  logic [N:0]   x2_d;
  logic [N-2:0] x3_d;

  generate
    if (LAT == 0) begin : g_direct
      assign x1_d = x1_i; assign x2_d = x2_i; assign x3_d = x3_i;
    end else begin : g_delay
      logic [N-1:0] s1 [LAT];
      logic [N:0]   s2 [LAT];
      logic [N-2:0] s3 [LAT];
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int k = 0; k < LAT; k++) begin s1[k] <= '0; s2[k] <= '0; s3[k] <= '0; end
        end else begin
          s1[0] <= x1_i; s2[0] <= x2_i; s3[0] <= x3_i;
          for (int k = 1; k < LAT; k++) begin s1[k] <= s1[k-1]; s2[k] <= s2[k-1]; s3[k] <= s3[k-1]; end
        end
      end
      assign x1_d = s1[LAT-1]; assign x2_d = s2[LAT-1]; assign x3_d = s3[LAT-1];

      // R7
      reset_clear_chk: assert property (@(posedge clk) !rst_n |-> (z1_o == '0 && z2_o == '0 && z3_o == '0));
    end
  endgenerate

  // R1
  z1_pass_chk: assert property (@(posedge clk) disable iff (!rst_n) z1_o == x1_d);
  // R2
  z2_congr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((int'(z2_o) + 2 * int'(x2_d)) % P2) == ((2 * int'(x1_d)) % P2));
  // R3
  z3_congr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((int'(z3_o) * P2 + int'(z2_o) + int'(x1_d)) % P3) == (int'(x3_d) % P3));
  // R6
  digit_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (z2_o != '1) && (z3_o != '1));
endmodule

bind mrc3_stage mrc3_stage_chk #(.N(N), .LAT(int'(MID_REG) + int'(OUT_REG))) u_chk (
  .clk(clk), .rst_n(rst_n), .x1_i(x1_i), .x2_i(x2_i), .x3_i(x3_i),
  .z1_o(z1_o), .z2_o(z2_o), .z3_o(z3_o)
);

// File: tb/sim_mrc3_stage.sv
module sim_mrc3_stage;
  localparam int N    = 6;
  localparam bit MID  = 1'b1;
  localparam bit OUTR = 1'b1;
  localparam int LAT  = int'(MID) + int'(OUTR);
  localparam int P1   = (1 << N) - 1;
  localparam int P2   = (1 << (N + 1)) - 1;
  localparam int P3   = (1 << (N - 1)) - 1;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic         rst_n;
  logic [N-1:0] x1_i;
  logic [N:0]   x2_i;
  logic [N-2:0] x3_i;
  logic [N-1:0] z1_o;
  logic [N:0]   z2_o, z2n_o;
  logic [N-2:0] z3_o;

  mrc3_stage #(.N(N), .MID_REG(MID), .OUT_REG(OUTR)) u0 (
    .clk(clk), .rst_n(rst_n), .x1_i(x1_i), .x2_i(x2_i), .x3_i(x3_i),
    .z1_o(z1_o), .z2_o(z2_o), .z2n_o(z2n_o), .z3_o(z3_o)
  );

  typedef struct { int z1; int z2; int z3; string tag; } exp_t;
  exp_t q[$];
  int compared = 0, mismatched = 0, qinv = 0;

  function automatic int ref_z2(int a, int b);
    int t = (2 * (a - b)) % P2;
    if (t < 0) t += P2;
    return t;
  endfunction

  function automatic int ref_z3(int a, int b, int c);
    int t = (c - a - ref_z2(a, b)) % P3;
    if (t < 0) t += P3;
    return (t * qinv) % P3;
  endfunction

  task automatic check(string what, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic apply(int a, int b, int c, string tag);
    exp_t e;
    @(negedge clk);
    x1_i = a[N-1:0]; x2_i = b[N:0]; x3_i = c[N-2:0];
    e.z1 = a; e.z2 = ref_z2(a, b); e.z3 = ref_z3(a, b, c); e.tag = tag;
    q.push_back(e);
    #1;
    if (q.size() > LAT) begin
      e = q.pop_front();
      check({e.tag, " R1 z1"}, int'(z1_o), e.z1);
      check({e.tag, " R2 z2"}, int'(z2_o), e.z2);
      check({e.tag, " R4 z2n"}, int'(z2n_o), (~e.z2) & P2);
      check({e.tag, " R3 z3"}, int'(z3_o), e.z3);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    #(20 * 100000);
    mismatched++;
    $display("FAIL watchdog expired actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    for (int v = 0; v < P3; v++) if ((P2 * v) % P3 == 1) qinv = v;
    rst_n = 1'b0; x1_i = '0; x2_i = '0; x3_i = '0;
    repeat (2) @(negedge clk);
    x1_i = 6'd33; x2_i = 7'd7; x3_i = 5'd5;
    repeat (3) @(negedge clk);
    #1;
    check("R7 reset z1", int'(z1_o), 0);
    check("R7 reset z2", int'(z2_o), 0);
    check("R7 reset z3", int'(z3_o), 0);
    rst_n = 1'b1;

    apply(33, 7, 5, "R3 example");
    apply(0, 0, 0, "R6 all-zero");
    apply(20, 20, 7, "R5 equal");
    apply(P1 - 1, P2 - 1, P3 - 1, "R5 max");
    apply(3, 100, 30, "R5 negative");
    apply(60, 1, 2, "R5 positive");
    apply(40, 9, (40 + ref_z2(40, 9)) % P3, "R6 z3 zero");
    apply(P1 - 1, 0, 0, "R5 x2 zero");
    apply(0, P2 - 1, 0, "R5 x1 zero");
    for (int i = 0; i < 3000; i++)
      apply(int'($urandom % P1), int'($urandom % P2), int'($urandom % P3), "R8 stream");
    for (int i = 0; i < LAT; i++) apply(0, 0, 0, "R8 flush");

    // R7: exact latency, output must not change before LAT edges
    @(negedge clk);
    x1_i = 6'd17; x2_i = 7'd0; x3_i = 5'd0;
    if (LAT > 0) begin
      repeat (LAT - 1) @(negedge clk);
      #1;
      check("R7 early z1", int'(z1_o), 0);
      @(negedge clk);
    end
    #1;
    check("R7 due z1", int'(z1_o), 17);
    finish_run();
  end
endmodule